// File: doc/BRIEF.md
# Periodic Down-Counter Timer

A small bus-attached timer holding a 16-bit counter that, once started, steps down by one on every tick of a fixed 1 MHz time base. The time base is made by dividing the system clock. When a tick finds the counter at zero, the counter is refilled from a software-written reload value and a single-cycle wrap pulse is raised. Software therefore sets up a periodic event by writing a period and then setting the start bit.

The bus side is a plain word interface with a 256-byte window. A strobe with a write flag moves one 32-bit word per cycle. Read data follows the address combinationally while a read is requested. Three registers are mapped. The control word has a start bit and a self-clearing soft-reset command bit. A write to the reload register also refills the live counter at once. The count register is read-only. A control write with the start bit clear is stored but does not halt a running counter. Only the soft-reset command or the hardware reset stops it.

Top module: `periodic_timer`

## Requirements
- R1: After hardware reset the control, reload and count registers read 0, wrap_o is low and the counter is stopped.
- R2: Only the exact byte offsets 0x00 (control), 0x08 (reload) and 0x0C (count) are mapped. Any other 8-bit address, including unaligned ones such as 0x09 and the hole at 0x04, reads as 0, and a write to it changes nothing.
- R3: A control write with bit 7 set stops the counter and clears control, reload and count to 0. The written word is not stored.
- R4: A control write with bit 0 set and bit 7 clear starts the counter, and the whole 32-bit word reads back from offset 0x00.
- R5: A control write with bit 0 clear stores the word but does not stop a counter that is already running.
- R6: A reload write keeps wdata_i[15:0], which reads back from 0x08 with bits 31:16 zero. It also puts that value into the live counter at the same clock edge, taking priority over a tick in that cycle.
- R7: A read of 0x0C returns the live counter in bits 15:0 and zeros above. A write to 0x0C has no effect.
- R8: The tick comes every CLK_HZ/TICK_HZ clocks (50 by default), counted from reset release. A running counter that is above zero drops by exactly one on each tick.
- R9: When a tick finds a running counter at 0, the counter reloads from the reload register and wrap_o is high for exactly the next cycle. wrap_o is low at all other times.
- R10: With a reload value of 0, a running counter stays at 0 and wrap_o pulses once per tick.
- R11: A stopped counter holds its value across ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high and we_i is low |
| wrap_o | output | 1 | One-cycle pulse on each reload from zero |

## Verification
A wrong divider phase or tick rate appears within one tick period, 50 clocks. It shows as a count read that is off by one, or as a wrap_o pulse in the wrong cycle. A wrong priority between reload write, soft reset and tick changes the next count read or the reload readback right away. A counter that stops when it should keep running shows only after the next tick, so the bench waits several tick periods before it reads the count again. wrap_o is compared on every cycle against a bench model built from the requirements, so a missing or stretched pulse is caught in the cycle where it occurs.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CNT_W = 16;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h08;
  localparam logic [7:0] OFS_COUNT  = 8'h0C;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RST_BIT = 7;

  typedef struct packed {
    logic             srst;
    logic             start;
    logic             load;
    logic [CNT_W-1:0] load_val;
  } tmr_cmd_t;
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      assign tick_o = (div_q == DW'(DIV - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end

      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R8
    end
  endgenerate
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DW-1:0]    rdata_o,
  output tmr_cmd_t         cmd_o,
  output logic [CNT_W-1:0] reload_o
);
  localparam int unsigned PAD_W = DW - CNT_W;

  logic [DW-1:0]    ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic wr, hit_ctrl, hit_reload, hit_count;

  assign wr         = req_i & we_i;
  assign hit_ctrl   = (addr_i == AW'(OFS_CTRL));
  assign hit_reload = (addr_i == AW'(OFS_RELOAD));
  assign hit_count  = (addr_i == AW'(OFS_COUNT));

  assign cmd_o.srst     = wr & hit_ctrl & wdata_i[CTRL_RST_BIT];
  assign cmd_o.start    = wr & hit_ctrl & wdata_i[CTRL_EN_BIT] & ~wdata_i[CTRL_RST_BIT];
  assign cmd_o.load     = wr & hit_reload;
  assign cmd_o.load_val = wdata_i[CNT_W-1:0];
  assign reload_o       = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (cmd_o.srst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr && hit_ctrl) ctrl_q   <= wdata_i;
      if (cmd_o.load)     reload_q <= cmd_o.load_val;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_ctrl)        rdata_o = ctrl_q;
      else if (hit_reload) rdata_o = {{PAD_W{1'b0}}, reload_q};
      else if (hit_count)  rdata_o = {{PAD_W{1'b0}}, count_i};
    end
  end

  AST_SRST_CLEARS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.srst |=> (ctrl_q == '0) && (reload_q == '0)); // R3
  AST_CTRL_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_ctrl && !wdata_i[CTRL_RST_BIT]) |=> ctrl_q == $past(wdata_i)); // R4
  AST_RELOAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (hit_ctrl || hit_reload)) |=> $stable(reload_q)); // R2
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_cmd_t         cmd_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;
  logic run_q, wrap_q, step, at_zero;

  assign at_zero = (count_q == '0);
  assign step    = run_q & tick_i & ~cmd_i.srst & ~cmd_i.load;
  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= 1'b0;
    else if (cmd_i.srst)    run_q <= 1'b0;
    else if (cmd_i.start)   run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= step & at_zero;
      if (cmd_i.srst)      count_q <= '0;
      else if (cmd_i.load) count_q <= cmd_i.load_val;
      else if (step)       count_q <= at_zero ? reload_i : count_q - 1'b1;
    end
  end

  AST_SRST_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.srst |=> (count_q == '0) && !run_q); // R3
  AST_LOAD_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.load && !cmd_i.srst) |=> count_q == $past(cmd_i.load_val)); // R6
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !at_zero && !cmd_i.load && !cmd_i.srst) |=> count_q == $past(count_q) - 1'b1); // R8
  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cmd_i.load && !cmd_i.srst) |=> $stable(count_q)); // R11
  AST_WRAP_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && at_zero && !cmd_i.load && !cmd_i.srst) |=> wrap_o && count_q == $past(reload_i)); // R9
  AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o); // R9
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cmd_i.srst) |=> run_q); // R5
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import timer_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        wrap_o
);
  localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic             tick;
  tmr_cmd_t         cmd;
  logic [CNT_W-1:0] reload, count;

  timer_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  timer_regs #(.AW(8), .DW(32)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .count_i  (count),
    .rdata_o  (rdata_o),
    .cmd_o    (cmd),
    .reload_o (reload)
  );

  timer_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cmd_i    (cmd),
    .reload_i (reload),
    .count_o  (count),
    .wrap_o   (wrap_o)
  );

  AST_COUNT_READ_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_COUNT) |-> rdata_o[31:16] == 16'h0); // R7
endmodule

// File: tb/periodic_timer_test.sv
module periodic_timer_test;
  localparam int unsigned DIV = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wrap;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periodic_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wrap_o(wrap)
  );

  // reference model from the requirements
  logic [31:0] m_ctrl;
  logic [15:0] m_reload, m_count;
  logic        m_run, m_wrap;
  int          m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_reload <= '0; m_count <= '0; m_run <= 1'b0; m_wrap <= 1'b0; m_div <= 0;
    end else begin
      logic tk, wr;
      tk = (m_div == DIV - 1);
      wr = req && we;
      m_div  <= tk ? 0 : m_div + 1;
      m_wrap <= 1'b0;
      if (wr && addr == 8'h00 && wdata[7]) begin
        m_ctrl <= '0; m_reload <= '0; m_count <= '0; m_run <= 1'b0;
      end else begin
        if (wr && addr == 8'h00) begin
          m_ctrl <= wdata;
          if (wdata[0]) m_run <= 1'b1;
        end
        if (wr && addr == 8'h08) begin
          m_reload <= wdata[15:0];
          m_count  <= wdata[15:0];
        end else if (m_run && tk) begin
          if (m_count == 0) begin m_count <= m_reload; m_wrap <= 1'b1; end
          else m_count <= m_count - 1'b1;
        end
      end
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00:   return m_ctrl;
      8'h08:   return {16'h0, m_reload};
      8'h0C:   return {16'h0, m_count};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R9 R10: wrap_o compared every cycle
  always @(negedge clk) if (rst_n && !done) check("R9 wrap_o", {31'h0, wrap}, {31'h0, m_wrap});

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 check(tag, rdata, model_read(a));
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rd_val(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd7731));
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_val(8'h00, a); check("R1 ctrl", a, 32'h0);
    rd_val(8'h08, a); check("R1 reload", a, 32'h0);
    rd_val(8'h0C, a); check("R1 count", a, 32'h0);
    check("R1 wrap", {31'h0, wrap}, 32'h0);
    // R6 reload loads counter at once, upper bits dropped
    wr_reg(8'h08, 32'hABCD_0005);
    rd_val(8'h08, a); check("R6 reload", a, 32'h0000_0005);
    rd_val(8'h0C, a); check("R6 count", a, 32'h0000_0005);
    // R11 stopped counter holds
    idle(3 * DIV);
    rd_val(8'h0C, a); check("R11 hold", a, 32'h0000_0005);
    // R4 start, word stored
    wr_reg(8'h00, 32'h1234_0001);
    rd_val(8'h00, a); check("R4 ctrl", a, 32'h1234_0001);
    // R8 R9 run through several periods
    for (int i = 0; i < 20; i++) begin idle(17); rd_chk("R8 count", 8'h0C); end
    // R5 clear enable does not stop
    wr_reg(8'h08, 32'd1000);
    wr_reg(8'h00, 32'h0000_0000);
    rd_val(8'h0C, a); idle(3 * DIV); rd_val(8'h0C, b);
    check("R5 still running", {31'h0, a != b}, 32'h1);
    rd_chk("R5 count", 8'h0C);
    // R10 zero reload
    wr_reg(8'h08, 32'h0);
    for (int i = 0; i < 6; i++) begin idle(23); rd_chk("R10 count", 8'h0C); end
    // R3 soft reset
    wr_reg(8'h08, 32'd77);
    wr_reg(8'h00, 32'hFFFF_FF81);
    rd_val(8'h00, a); check("R3 ctrl", a, 32'h0);
    rd_val(8'h08, a); check("R3 reload", a, 32'h0);
    rd_val(8'h0C, a); check("R3 count", a, 32'h0);
    // R7 count write ignored
    wr_reg(8'h08, 32'd40);
    wr_reg(8'h0C, 32'h0000_1234);
    idle(2 * DIV);
    rd_val(8'h0C, a); check("R7 count", a, 32'd40);
    // R2 unmapped
    wr_reg(8'h04, 32'hDEAD_BEEF);
    wr_reg(8'h09, 32'h0000_0011);
    wr_reg(8'h01, 32'h0000_0001);
    rd_val(8'h04, a); check("R2 hole", a, 32'h0);
    rd_val(8'h09, a); check("R2 unaligned", a, 32'h0);
    rd_val(8'h08, a); check("R2 reload kept", a, 32'd40);
    rd_val(8'h00, a); check("R2 ctrl kept", a, 32'h0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  ra;
      logic [31:0] d;
      case ($urandom_range(0, 7))
        0, 1:    ra = 8'h00;
        2, 3:    ra = 8'h08;
        4:       ra = 8'h0C;
        5:       ra = 8'h04;
        6:       ra = 8'h0A;
        default: ra = 8'hFC;
      endcase
      d = $urandom;
      if (ra == 8'h08 && $urandom_range(0, 3) != 0) d = $urandom_range(0, 60);
      if ($urandom_range(0, 9) != 0) d[7] = 1'b0;
      if ($urandom_range(0, 1) == 0) wr_reg(ra, d);
      idle($urandom_range(0, 120));
      rd_chk("R8 random", 8'h0C);
      rd_chk("R2 random", ra);
    end
    finish_run();
  end
endmodule